// File: doc/BRIEF.md
# Scaler Initial Phase Calculator

This block works out the starting phase word for one axis (horizontal or vertical) of a polyphase image scaler. It takes the scale ratio as a 16.16 fixed-point number (source size over destination size). It also takes a select that says whether the plane is subsampled by two, and a flag that asks for chroma co-siting. From these it produces the 16-bit value that the scaler's phase register expects.

The internal phase starts at the left or top pixel edge rather than the pixel centre, which is minus one half. Half of the per-output step is then added, divided by the subsampling factor. For co-sited subsampled chroma, a further quarter-pixel shift is added. A negative phase is wrapped up by one whole pixel and leaves the trip bit clear. A non-negative phase sets the trip bit. A range flag reports phases that fall outside the window the scaler accepts.

Driver logic presents one request with `req_valid` and reads the registered result one clock later.

Top module: `scl_phase_calc`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `res_valid`, `res_phase` and `res_range_err` are all zero.
- R2: Each clock edge with `req_valid` high produces exactly one result, with `res_valid` high, after that one edge. `res_valid` is low in every other cycle.
- R3: With `req_half` = 0 (no subsampling), the intermediate phase is -0x8000 plus `req_scale` divided by 2, rounded down.
- R4: With `req_half` = 1 (subsampling by two), the scale term is `req_scale` divided by 4, rounded down.
- R5: With `req_half` = 1, `req_cosite` = 1 adds a further 0x4000 to the intermediate phase. With `req_half` = 0, `req_cosite` has no effect on any output.
- R6: A negative intermediate phase is increased by 0x10000 before encoding, and bit 0 of `res_phase` is 0.
- R7: A non-negative intermediate phase is encoded unchanged, and bit 0 of `res_phase` is 1.
- R8: `res_phase[15:1]` equals bits 17 to 3 of the adjusted phase. This is the adjusted phase shifted right by 2 and masked with 0xFFFE.
- R9: `res_range_err` is 1 exactly when the intermediate phase is above 0x18000 or below -0x8000. The bound 0x18000 itself is in range.
- R10: A 0.25 ratio (0x4000, no subsampling, no co-siting) gives 0x2800. A 4.0 ratio (0x40000) gives 0x6001 with no range error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_scale | input | 32 | Scale ratio, 16.16 fixed point, source over destination |
| req_half | input | 1 | 0: no subsampling, 1: subsampled by two |
| req_cosite | input | 1 | Request co-sited chroma shift |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_phase | output | 16 | Phase word: fraction field in bits 15:1, trip in bit 0 |
| res_range_err | output | 1 | Intermediate phase outside the accepted window |

## Verification
The hardest cases to reach sit at the exact edges of the encoding.

- Phase exactly zero is where the trip bit flips. Ratio 1.0 reaches it without subsampling. With subsampling and co-siting, the quarter-pixel shift plus ratio 1.0 also cancels to zero.
- Phase exactly 0x18000 is the last in-range value, next to the first out-of-range one.

The stimulus includes these ratios as named cases: 0x10000, 0x40000 and 0x40002, plus a subsampled ratio of 0x80000 and one of 0x80004. On top of these it runs a sweep from 0.25 to 3.0 across all four combinations of the subsampling select and the co-siting flag. Back-to-back requests keep the scoreboard pairing honest.

// File: rtl/scl_phase_pkg.sv
package scl_phase_pkg;

  typedef enum logic {
    SUB_NONE = 1'b0,
    SUB_HALF = 1'b1
  } sub_mode_e;

  localparam int DEF_SCALE_W = 32;
  localparam int DEF_FRAC_W  = 16;

endpackage

// File: rtl/scl_phase_sum.sv
module scl_phase_sum #(
  parameter int SCALE_W = 32,
  parameter int FRAC_W  = 16,
  parameter int ACC_W   = SCALE_W + 2
) (
  input  logic [SCALE_W-1:0]      scale,
  input  logic                    half,
  input  logic                    cosite,
  output logic signed [ACC_W-1:0] phase
);
  import scl_phase_pkg::*;

  localparam int HALF_PIX    = 1 << (FRAC_W - 1);
  localparam int QUARTER_PIX = 1 << (FRAC_W - 2);

  sub_mode_e          mode;
  logic [ACC_W-1:0]   step;
  logic [ACC_W-1:0]   shift;

  always_comb begin
    mode  = sub_mode_e'(half);
    step  = (mode == SUB_HALF) ? ACC_W'(scale >> 2) : ACC_W'(scale >> 1);
    shift = (mode == SUB_HALF && cosite) ? ACC_W'(QUARTER_PIX) : '0;
    phase = $signed(step) + $signed(shift) - $signed(ACC_W'(HALF_PIX));
  end

endmodule

// File: rtl/scl_phase_encode.sv
module scl_phase_encode #(
  parameter int FRAC_W = 16,
  parameter int ACC_W  = 34,
  parameter int WORD_W = FRAC_W
) (
  input  logic signed [ACC_W-1:0] phase,
  output logic [WORD_W-1:0]       word,
  output logic                    range_err
);
  localparam int HALF_PIX = 1 << (FRAC_W - 1);
  localparam int ONE_PIX  = 1 << FRAC_W;
  localparam logic signed [ACC_W-1:0] LO_LIM  = -ACC_W'(HALF_PIX);
  localparam logic signed [ACC_W-1:0] HI_LIM  = ACC_W'(3 * HALF_PIX);
  localparam logic [ACC_W-1:0]        FLD_MSK = ACC_W'((1 << WORD_W) - 2);

  logic             neg;
  logic [ACC_W-1:0] adj;

  always_comb begin
    neg       = phase[ACC_W-1];
    adj       = neg ? (phase + ACC_W'(ONE_PIX)) : phase;
    range_err = (phase < LO_LIM) || (phase > HI_LIM);
    word      = WORD_W'((adj >> 2) & FLD_MSK) | WORD_W'(!neg);
  end

endmodule

// File: rtl/scl_phase_calc.sv
module scl_phase_calc #(
  parameter int SCALE_W = scl_phase_pkg::DEF_SCALE_W,
  parameter int FRAC_W  = scl_phase_pkg::DEF_FRAC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [SCALE_W-1:0] req_scale,
  input  logic               req_half,
  input  logic               req_cosite,
  output logic               res_valid,
  output logic [FRAC_W-1:0]  res_phase,
  output logic               res_range_err
);
  localparam int ACC_W = SCALE_W + 2;

  logic signed [ACC_W-1:0] phase_c;
  logic [FRAC_W-1:0]       word_c;
  logic                    err_c;

  scl_phase_sum #(.SCALE_W(SCALE_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_sum (
    .scale (req_scale),
    .half  (req_half),
    .cosite(req_cosite),
    .phase (phase_c)
  );

  scl_phase_encode #(.FRAC_W(FRAC_W), .ACC_W(ACC_W), .WORD_W(FRAC_W)) u_enc (
    .phase    (phase_c),
    .word     (word_c),
    .range_err(err_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid     <= 1'b0;
      res_phase     <= '0;
      res_range_err <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_phase     <= word_c;
        res_range_err <= err_c;
      end
    end
  end

endmodule

// File: rtl/scl_phase_calc_chk.sv
module scl_phase_calc_chk #(
  parameter int SCALE_W = 32,
  parameter int FRAC_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [SCALE_W-1:0] req_scale,
  input logic               req_half,
  input logic               req_cosite,
  input logic               res_valid,
  input logic [FRAC_W-1:0]  res_phase,
  input logic               res_range_err
);
  localparam logic [SCALE_W-1:0] UNITY = SCALE_W'(1 << FRAC_W);
  localparam logic [SCALE_W-1:0] TOP_R = SCALE_W'(4 << FRAC_W);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!res_valid && res_phase == '0 && !res_range_err)); // R1

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(req_valid)); // R2

  AST_UNITY_TRIP: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid) && $past(req_scale) == UNITY && !$past(req_half))
      |-> (res_valid && res_phase == FRAC_W'(1))); // R7

  AST_BELOW_UNITY: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid) && $past(req_scale) < UNITY && !$past(req_half))
      |-> !res_phase[0]); // R6

  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid) && $past(req_scale) <= TOP_R && !$past(req_half))
      |-> !res_range_err); // R9

  AST_COSITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid) && !$past(req_half) && $past(req_scale) == UNITY && $past(req_cosite))
      |-> res_phase[0]); // R5

endmodule

bind scl_phase_calc scl_phase_calc_chk #(.SCALE_W(SCALE_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/scl_phase_calc_tb.sv
module scl_phase_calc_tb_top;

  typedef struct {
    logic [15:0] word;
    logic        err;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_scale = '0;
  logic        req_half = 1'b0;
  logic        req_cosite = 1'b0;
  logic        res_valid;
  logic [15:0] res_phase;
  logic        res_range_err;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;
  exp_t sb[$];

  always #10 clk = ~clk;

  scl_phase_calc dut_i (.*);

  function automatic exp_t model(logic [31:0] s, logic h, logic c, string tag);
    longint p;
    exp_t   e;
    p = -32768;
    if (h && c) p += 16384;
    p += h ? longint'(s >> 2) : longint'(s >> 1);
    e.err = (p > 98304) || (p < -32768);
    e.word[0] = (p >= 0);
    if (p < 0) p += 65536;
    e.word[15:1] = 15'((p >> 3) & 64'h7fff);
    e.tag = tag;
    return e;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] s, logic h, logic c, string tag);
    @(negedge clk);
    req_valid  = 1'b1;
    req_scale  = s;
    req_half   = h;
    req_cosite = c;
    sb.push_back(model(s, h, c, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(res_phase == e.word, {e.tag, " word"}, res_phase, e.word);
        check(res_range_err == e.err, {e.tag, " range"}, res_range_err, e.err);
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!res_valid && res_phase == 0 && !res_range_err, "R1 reset", res_phase, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!res_valid && res_phase == 0, "R1 after reset", res_valid, 0);

    drive(32'h0000_4000, 1'b0, 1'b0, "R10 R6 quarter ratio");
    drive(32'h0004_0000, 1'b0, 1'b0, "R10 R7 ratio four");
    drive(32'h0001_0000, 1'b0, 1'b0, "R7 zero phase");
    drive(32'h0000_FFFE, 1'b0, 1'b0, "R6 just below zero");
    drive(32'h0004_0002, 1'b0, 1'b0, "R9 above window");
    drive(32'h0008_0000, 1'b1, 1'b0, "R4 R9 half sub at limit");
    drive(32'h0008_0004, 1'b1, 1'b0, "R4 R9 half sub past limit");
    drive(32'h0001_0000, 1'b1, 1'b1, "R5 cosite zero phase");
    drive(32'h0001_0000, 1'b0, 1'b1, "R5 cosite ignored");
    drive(32'h0002_3458, 1'b0, 1'b0, "R3 R8 field bits");
    idle();
    repeat (3) @(negedge clk);
    check(!res_valid, "R2 idle", res_valid, 0);

    for (int c = 0; c < 4; c++) begin
      for (logic [31:0] s = 32'h4000; s <= 32'h30000; s += 32'h1000) begin
        drive(s, c[1], c[0], "R3 R4 R5 R8 sweep");
      end
      idle();
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R2 all results seen", sb.size(), 0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

endmodule